// File: doc/BRIEF.md
# Vector Instruction Sequencer with Data-Availability Handshake

This block is the control unit of one processing cell in an array of cells. A small configuration memory holds the cell's program. Each instruction word carries an operation select, an element count and two address descriptors, one for each local memory port. The sequencer steps through the program with an instruction counter. For each instruction it strobes the descriptors into the address generators once, then issues the operation select to the arithmetic element once per element until the count runs out.

The cell waits in a loading state until the upstream side shows that all input data is present. It then acknowledges that data and moves into the executing state. When the program ends, the sequencer returns to loading and raises a valid flag toward the downstream cell. The flag holds until the downstream cell acknowledges it. Because the cell is back in loading as soon as its own program ends, it can take in the next data block while the next cell is still working on the previous one. Chained cells therefore form a block-level pipeline that needs no global schedule.

Top module: `vseq_ctrl`

## Requirements
- R1: After reset the cell is loading (`executing`=0), and `in_take`, `desc_load`, `op_valid`, `prog_done` and `dn_valid` are all 0.
- R2: While loading, with `in_avail`=1 and `dn_valid`=0, `in_take` is 1 for exactly that cycle and `executing` is 1 from the next cycle. `in_take` stays 0 while `dn_valid` is 1 or while executing.
- R3: Each instruction with a nonzero count gives one `desc_load` cycle. During it, `desc_a` equals word bits [15:8] and `desc_b` equals bits [7:0]. It comes before that instruction's first operation, and never in the same cycle as `op_valid`.
- R4: Right after an instruction's `desc_load`, `op_valid` is 1 for exactly count consecutive cycles. During them, `op_code` equals word bits [25:22] and the count is word bits [21:16].
- R5: Every run starts at address 0 and executes the instructions in increasing address order.
- R6: An instruction whose count field is 0 produces neither `desc_load` nor `op_valid`, and the sequencer goes on to the next address.
- R7: Op code 4'hF ends the program. `prog_done` is 1 for one cycle, and in that cycle `executing` is 0 and `dn_valid` is 1.
- R8: A program with no end op code ends after the last memory address, exactly as R7 describes.
- R9: `dn_valid`, once set, holds until a cycle with `dn_ack`=1, and is 0 from the cycle after that.
- R10: A write through `cfg_we` while executing leaves the memory unchanged. A write while loading updates the addressed word for the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration memory write enable |
| cfg_addr | input | AW (3) | Configuration memory write address |
| cfg_wdata | input | 26 | Instruction word: op[25:22], count[21:16], desc_a[15:8], desc_b[7:0] |
| in_avail | input | 1 | Upstream: all input data for the next run is present |
| in_take | output | 1 | Upstream: input data accepted, execution starts |
| desc_load | output | 1 | Address generators take the descriptors this cycle |
| desc_a | output | 8 | Descriptor for memory port A |
| desc_b | output | 8 | Descriptor for memory port B |
| op_valid | output | 1 | One element operation is issued this cycle |
| op_code | output | 4 | Operation select for the arithmetic element |
| executing | output | 1 | 1 while executing, 0 while loading |
| prog_done | output | 1 | One-cycle pulse when the program ends |
| dn_valid | output | 1 | Downstream: results ready, held until acknowledged |
| dn_ack | input | 1 | Downstream: results taken |

## Verification
The assertions check the local handshake and ordering rules on every cycle. These are: acceptance only while loading with no pending valid, execution starting the cycle after acceptance, descriptors always followed by an operation, operations only while executing, the end pulse coinciding with valid and loading, and valid holding until acknowledged. Whether the right instructions ran in the right order, with correct counts, codes and descriptors, can only be seen from the bench's scenarios. These compare the observed stream of descriptor, operation and end events against a sequence rebuilt from the programmed words. The scenarios cover zero counts, programs without an end code, an immediate end code and configuration writes made mid-run.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SETUP = 2'd2,
    ST_RUN   = 2'd3
  } vseq_state_e;

endpackage

// File: rtl/vseq_cfg_mem.sv
module vseq_cfg_mem #(
  parameter int AW = 3,
  parameter int IW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q[g] <= '0;
      else if (we && (waddr == AW'(g)))
        word_q[g] <= wdata;
    end
  end

  assign rdata = word_q[raddr];
endmodule

// File: rtl/vseq_opcount.sv
module vseq_opcount #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (dec && (cnt_q != '0))
      cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/vseq_dnhs.sv
module vseq_dnhs (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid <= 1'b0;
    else if (set)
      valid <= 1'b1;
    else if (ack)
      valid <= 1'b0;
  end
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl #(
  parameter int AW     = 3,
  parameter int OP_W   = 4,
  parameter int CNT_W  = 6,
  parameter int DESC_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [AW-1:0]                   cfg_addr,
  input  logic [OP_W+CNT_W+2*DESC_W-1:0]  cfg_wdata,
  input  logic                            in_avail,
  output logic                            in_take,
  output logic                            desc_load,
  output logic [DESC_W-1:0]               desc_a,
  output logic [DESC_W-1:0]               desc_b,
  output logic                            op_valid,
  output logic [OP_W-1:0]                 op_code,
  output logic                            executing,
  output logic                            prog_done,
  output logic                            dn_valid,
  input  logic                            dn_ack
);
  import vseq_pkg::*;

  localparam int IW    = OP_W + CNT_W + 2*DESC_W;
  localparam int DEPTH = 1 << AW;
  localparam logic [OP_W-1:0] END_OP = '1;

  function automatic logic [OP_W-1:0] f_op(input logic [IW-1:0] w);
    return w[IW-1 -: OP_W];
  endfunction

  function automatic logic [CNT_W-1:0] f_cnt(input logic [IW-1:0] w);
    return w[2*DESC_W +: CNT_W];
  endfunction

  function automatic logic [DESC_W-1:0] f_da(input logic [IW-1:0] w);
    return w[DESC_W +: DESC_W];
  endfunction

  function automatic logic [DESC_W-1:0] f_db(input logic [IW-1:0] w);
    return w[0 +: DESC_W];
  endfunction

  vseq_state_e   state_q, state_d;
  logic [AW:0]   pc_q, pc_d;
  logic [IW-1:0] ir_q;
  logic [IW-1:0] mem_rdata;
  logic          past_end;
  logic          is_end;
  logic          is_empty;
  logic          ev_start;
  logic          ev_finish;
  logic          ev_fetch_ok;
  logic          cnt_last;
  logic          done_q;

  vseq_cfg_mem #(.AW(AW), .IW(IW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we && (state_q == ST_LOAD)),
    .waddr (cfg_addr),
    .wdata (cfg_wdata),
    .raddr (pc_q[AW-1:0]),
    .rdata (mem_rdata)
  );

  assign past_end    = pc_q[AW];
  assign is_end      = past_end || (f_op(mem_rdata) == END_OP);
  assign is_empty    = (f_cnt(mem_rdata) == '0);
  assign ev_start    = (state_q == ST_LOAD) && in_avail && !dn_valid;
  assign ev_finish   = (state_q == ST_FETCH) && is_end;
  assign ev_fetch_ok = (state_q == ST_FETCH) && !is_end && !is_empty;

  vseq_opcount #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_fetch_ok),
    .load_val (f_cnt(mem_rdata)),
    .dec      (state_q == ST_RUN),
    .last     (cnt_last)
  );

  vseq_dnhs u_hs (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (ev_finish),
    .ack   (dn_ack),
    .valid (dn_valid)
  );

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    unique case (state_q)
      ST_LOAD: begin
        if (ev_start) begin
          state_d = ST_FETCH;
          pc_d    = '0;
        end
      end
      ST_FETCH: begin
        if (is_end)
          state_d = ST_LOAD;
        else if (is_empty)
          pc_d = pc_q + 1'b1;
        else
          state_d = ST_SETUP;
      end
      ST_SETUP: state_d = ST_RUN;
      ST_RUN: begin
        if (cnt_last) begin
          state_d = ST_FETCH;
          pc_d    = pc_q + 1'b1;
        end
      end
      default: state_d = ST_LOAD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      pc_q    <= '0;
      ir_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      done_q  <= ev_finish;
      if (ev_fetch_ok)
        ir_q <= mem_rdata;
    end
  end

  assign in_take   = ev_start;
  assign executing = (state_q != ST_LOAD);
  assign desc_load = (state_q == ST_SETUP);
  assign desc_a    = f_da(ir_q);
  assign desc_b    = f_db(ir_q);
  assign op_valid  = (state_q == ST_RUN);
  assign op_code   = f_op(ir_q);
  assign prog_done = done_q;

  localparam int UNUSED_DEPTH = DEPTH;
endmodule

// File: rtl/vseq_ctrl_chk.sv
module vseq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic in_avail,
  input logic in_take,
  input logic desc_load,
  input logic op_valid,
  input logic executing,
  input logic prog_done,
  input logic dn_valid,
  input logic dn_ack
);
  assert_take_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |-> (!executing && !dn_valid && in_avail));

  assert_take_starts_exec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |=> executing);

  assert_desc_then_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_load |=> op_valid);

  assert_desc_not_with_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_load && op_valid));

  assert_op_only_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> executing);

  assert_done_sets_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> (dn_valid && !executing));

  assert_valid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ack) |=> dn_valid);

  assert_valid_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ack) |=> !dn_valid);
endmodule

bind vseq_ctrl vseq_ctrl_chk chk_i (.*);

// File: tb/vseq_ctrl_tb_top.sv
module vseq_ctrl_tb_top;
  localparam int AW = 3;
  localparam int DEPTH = 8;
  localparam int IW = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [IW-1:0] cfg_wdata = '0;
  logic in_avail = 1'b0;
  logic dn_ack = 1'b0;
  logic in_take, desc_load, op_valid, executing, prog_done, dn_valid;
  logic [7:0] desc_a, desc_b;
  logic [3:0] op_code;

  always #2.5 clk = ~clk;

  vseq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_avail(in_avail), .in_take(in_take),
    .desc_load(desc_load), .desc_a(desc_a), .desc_b(desc_b),
    .op_valid(op_valid), .op_code(op_code), .executing(executing),
    .prog_done(prog_done), .dn_valid(dn_valid), .dn_ack(dn_ack)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // expected event: kind 0 = descriptor, 1 = operation, 2 = end
  typedef struct packed {
    logic [1:0] kind;
    logic [3:0] code;
    logic [7:0] a;
    logic [7:0] b;
  } ev_t;

  ev_t exp_q[$];
  logic [IW-1:0] prog [DEPTH];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [IW-1:0] mk(input logic [3:0] op, input logic [5:0] cnt,
                                       input logic [7:0] a, input logic [7:0] b);
    return {op, cnt, a, b};
  endfunction

  task automatic wr(input int addr, input logic [IW-1:0] w, input bit track);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = w;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (track) prog[addr] = w;
  endtask

  // driver: rebuild the expected event stream from the bench copy (R5, R6, R8)
  task automatic build_expect();
    ev_t e;
    for (int i = 0; i < DEPTH; i++) begin
      if (prog[i][25:22] == 4'hF) begin
        e = '{kind: 2'd2, code: 4'h0, a: 8'h0, b: 8'h0};
        exp_q.push_back(e);
        return;
      end
      if (prog[i][21:16] != 6'd0) begin
        e = '{kind: 2'd0, code: 4'h0, a: prog[i][15:8], b: prog[i][7:0]};
        exp_q.push_back(e);
        for (int k = 0; k < int'(prog[i][21:16]); k++) begin
          e = '{kind: 2'd1, code: prog[i][25:22], a: 8'h0, b: 8'h0};
          exp_q.push_back(e);
        end
      end
    end
    e = '{kind: 2'd2, code: 4'h0, a: 8'h0, b: 8'h0};
    exp_q.push_back(e);
  endtask

  // monitor: compare produced events against the queue
  always @(negedge clk) begin
    if (rst_n && (desc_load || op_valid || prog_done)) begin
      ev_t e;
      ev_t got;
      got.kind = desc_load ? 2'd0 : (op_valid ? 2'd1 : 2'd2);
      got.code = (got.kind == 2'd1) ? op_code : 4'h0;
      got.a    = (got.kind == 2'd0) ? desc_a : 8'h0;
      got.b    = (got.kind == 2'd0) ? desc_b : 8'h0;
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected event kind", int'(got.kind), -1);
      end else begin
        e = exp_q.pop_front();
        check(got.kind == e.kind, "R5/R6", "event kind", int'(got.kind), int'(e.kind));
        if (e.kind == 2'd0 && got.kind == 2'd0) begin
          check(got.a == e.a, "R3", "desc_a", int'(got.a), int'(e.a));
          check(got.b == e.b, "R3", "desc_b", int'(got.b), int'(e.b));
        end
        if (e.kind == 2'd1 && got.kind == 2'd1)
          check(got.code == e.code, "R4", "op_code", int'(got.code), int'(e.code));
        if (got.kind == 2'd2) begin
          check(!executing, "R7", "executing at end", int'(executing), 0);
          check(dn_valid, "R7", "dn_valid at end", int'(dn_valid), 1);
        end
      end
    end
  end

  // start a run and check the acceptance pulse (R2)
  task automatic start_run();
    @(posedge clk); #1;
    in_avail = 1'b1;
    @(negedge clk);
    check(in_take == 1'b1, "R2", "in_take on start", int'(in_take), 1);
    @(posedge clk); #1;
    in_avail = 1'b0;
    @(negedge clk);
    check(in_take == 1'b0, "R2", "in_take one cycle", int'(in_take), 0);
    check(executing == 1'b1, "R2", "executing after take", int'(executing), 1);
  endtask

  task automatic finish_run(input string req);
    while (!dn_valid) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, req, "events left", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic ack_down();
    @(posedge clk); #1;
    dn_ack = 1'b1;
    @(posedge clk); #1;
    dn_ack = 1'b0;
    @(negedge clk);
    check(dn_valid == 1'b0, "R9", "dn_valid after ack", int'(dn_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) prog[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(executing == 1'b0, "R1", "executing in reset", int'(executing), 0);
    check(dn_valid == 1'b0, "R1", "dn_valid in reset", int'(dn_valid), 0);
    check(op_valid == 1'b0 && desc_load == 1'b0, "R1", "issue in reset",
          int'(op_valid) + int'(desc_load), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_take == 1'b0 && prog_done == 1'b0, "R1", "take/done after reset",
          int'(in_take) + int'(prog_done), 0);

    // program A: mixed counts, a zero count (R6), end code (R7)
    wr(0, mk(4'h3, 6'd3, 8'h10, 8'h20), 1'b1);
    wr(1, mk(4'h5, 6'd0, 8'hAA, 8'hBB), 1'b1);
    wr(2, mk(4'h7, 6'd2, 8'h31, 8'h42), 1'b1);
    wr(3, mk(4'hF, 6'd0, 8'h00, 8'h00), 1'b1);
    build_expect();
    start_run();
    finish_run("R7");

    // valid held and no start while pending (R9, R2)
    @(posedge clk); #1;
    in_avail = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(dn_valid == 1'b1, "R9", "dn_valid held", int'(dn_valid), 1);
      check(in_take == 1'b0 && executing == 1'b0, "R2", "no start while pending",
            int'(in_take) + int'(executing), 0);
    end
    @(posedge clk); #1;
    in_avail = 1'b0;
    ack_down();

    // program B: no end code, runs to last address (R8)
    for (int i = 0; i < DEPTH; i++)
      wr(i, mk(4'(i), 6'd1 + 6'(i % 2), 8'(8'h50 + i), 8'(8'h60 + i)), 1'b1);
    build_expect();
    start_run();
    // write during execution must be ignored (R10)
    wr(0, mk(4'hF, 6'd0, 8'h00, 8'h00), 1'b0);
    finish_run("R8");
    ack_down();

    // rerun: entry 0 must still hold the old word (R10)
    build_expect();
    start_run();
    finish_run("R10");
    ack_down();

    // write while loading takes effect (R10)
    wr(0, mk(4'h9, 6'd4, 8'h77, 8'h88), 1'b1);
    wr(1, mk(4'hF, 6'd0, 8'h00, 8'h00), 1'b1);
    build_expect();
    start_run();
    finish_run("R10");
    ack_down();

    // immediate end code: no issue at all (R7)
    wr(0, mk(4'hF, 6'd5, 8'h01, 8'h02), 1'b1);
    build_expect();
    start_run();
    finish_run("R7");
    ack_down();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule